// File: doc/BRIEF.md
# SAR Conversion Sequencer with Short-Cycle

This block is the digital core of a successive-approximation converter. It runs from a system clock. A rising edge on an asynchronous convert-start input is synchronised and launches one conversion. A gated bit clock then runs, and each of its rising edges is one step of the search. On the first step the block loads a trial code into a negative-true result register. On each later step it keeps or rejects the pending bit, using a one-bit comparator result, and clears the next lower bit as the new trial. The register drives the external DAC directly.

A busy status output is high for the whole conversion. It falls a fixed number of system cycles after the last decision, so the result is already stable when it falls. A two-bit resolution select ends the search after 8, 10 or the full 12 bits. The result stays in complementary form. An inverted-MSB output lets a consumer read the same register as complementary two's complement instead of complementary offset binary.

Top module: `sar_seq_top`

## Requirements
- R1: While reset is high and on the cycle after it, busy_o and bit_clk_o are 0, data_n_o is all ones and msb_inv_o is 0.
- R2: A rising edge of start_in while idle makes busy_o high from the third rising clk edge after start_in rose (two synchroniser flops, then the launch flop).
- R3: bit_clk_o is 0 whenever busy_o is 0.
- R4: During a conversion of n bits, bit_clk_o has exactly n+1 rising edges, each high phase lasts HALF clk cycles, and rising edges are 2*HALF cycles apart.
- R5: On the first bit-clock rising edge, data_n_o becomes MSB 0 with all other bits 1, whatever the comparator says.
- R6: On each later step, the pending bit keeps its trial value 0 if cmp_in is 1 at that edge and becomes 1 if cmp_in is 0. The next lower bit is then cleared as the new trial, except after the last decision. With a comparator that reports input >= ~data_n_o, the final data_n_o is the bitwise complement of the input code truncated to n bits.
- R7: data_n_o changes only at clk edges where bit_clk_o rises, or under reset.
- R8: busy_o falls POST clk cycles after the edge of the last decision, so it is high for 1 + 2*HALF*n + POST cycles, and data_n_o does not change at the edge where busy_o falls.
- R9: res_sel is captured at launch: 2'b00 and 2'b11 select 12 bits, 2'b01 selects 10 bits and 2'b10 selects 8 bits. With fewer bits, the unconverted low bits of data_n_o stay 1.
- R10: msb_inv_o is always the inverse of data_n_o[11].
- R11: A rising edge of start_in while busy_o is high is ignored: the result, the number of bit-clock edges and the busy duration are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Asynchronous convert-start; a rising edge launches a conversion |
| res_sel | input | 2 | Resolution select, captured at launch |
| cmp_in | input | 1 | Comparator: 1 when the analog input is at or above the DAC output |
| busy_o | output | 1 | Conversion in progress |
| bit_clk_o | output | 1 | Gated bit clock; low when idle |
| data_n_o | output | 12 | Negative-true trial/result register, also the DAC code |
| msb_inv_o | output | 1 | Inverted MSB of data_n_o |

## Verification
The bench builds the block with WIDTH 12, HALF 2 and POST 3. POST is then longer than the bit-clock high phase, so the last high phase ends before busy falls. A POST error of one cycle shows up in the measured busy length, apart from any bit-clock effect. With the short periods, all three resolutions plus a start pulse during a conversion each finish in under sixty cycles. A comparator model computed from the register output drives every search, including the all-zero, all-one and half-scale codes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_HOLD = 2'b10
    } seq_state_t;

    typedef struct packed {
        logic fire;
        logic first;
        logic last;
    } step_t;

    // Resolution select decode: 01 -> width-2, 10 -> width-4, else full width.
    function automatic int unsigned res_bits(input logic [1:0] sel, input int unsigned width);
        case (sel)
            2'b01:   return width - 2;
            2'b10:   return width - 4;
            default: return width;
        endcase
    endfunction

endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= async_in;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise_o = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/sar_bitclk.sv
module sar_bitclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic run,
    output logic step_o,
    output logic bclk_o
);
    localparam int CW = $clog2(2 * HALF);
    localparam logic [CW-1:0] CNT_LAST = CW'(2 * HALF - 1);
    localparam logic [CW-1:0] CNT_FALL = CW'(HALF);

    logic [CW-1:0] cnt;
    logic          bclk_q;

    assign step_o = en && run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt    <= '0;
            bclk_q <= 1'b0;
        end else begin
            if (cnt == CNT_LAST) cnt <= run ? '0 : cnt;
            else                 cnt <= cnt + 1'b1;
            if (step_o)                bclk_q <= 1'b1;
            else if (cnt == CNT_FALL)  bclk_q <= 1'b0;
        end
    end

    assign bclk_o = bclk_q;
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = 12,
    parameter int IW    = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    input  logic [IW-1:0]    idx,
    input  logic             cmp,
    output logic [WIDTH-1:0] q_n
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            localparam logic [IW-1:0] DEC_AT   = IW'(WIDTH - i);
            localparam logic [IW-1:0] TRIAL_AT = IW'(WIDTH - 1 - i);
            localparam logic          INIT_V   = (i == WIDTH - 1) ? 1'b0 : 1'b1;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_n[i] <= 1'b1;
                end else if (step.fire) begin
                    if (step.first)                           q_n[i] <= INIT_V;
                    else if (idx == DEC_AT)                   q_n[i] <= ~cmp;
                    else if (idx == TRIAL_AT && !step.last)   q_n[i] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = 12,
    parameter int HALF  = 2,
    parameter int POST  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    input  logic [1:0]       res_sel,
    input  logic             cmp_in,
    output logic             busy_o,
    output logic             bit_clk_o,
    output logic [WIDTH-1:0] data_n_o,
    output logic             msb_inv_o
);
    localparam int IW = $clog2(WIDTH + 1);
    localparam int PW = (POST > 1) ? $clog2(POST) : 1;
    localparam logic [PW-1:0] POST_LAST = PW'(POST - 1);

    seq_state_t    state;
    logic [IW-1:0] idx;
    logic [IW-1:0] nbits;
    logic [PW-1:0] pcnt;
    logic          start_rise;
    logic          raw_step;
    logic          clk_en;
    step_t         step;

    sar_start_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (start_in),
        .rise_o   (start_rise)
    );

    assign clk_en = (state == ST_RUN) || (state == ST_HOLD && pcnt != POST_LAST);

    sar_bitclk #(.HALF(HALF)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .en     (clk_en),
        .run    (state == ST_RUN),
        .step_o (raw_step),
        .bclk_o (bit_clk_o)
    );

    always_comb begin
        step.fire  = raw_step && (state == ST_RUN);
        step.first = (idx == '0);
        step.last  = (idx == nbits);
    end

    sar_trial_reg #(.WIDTH(WIDTH), .IW(IW)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .idx  (idx),
        .cmp  (cmp_in),
        .q_n  (data_n_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            nbits <= IW'(WIDTH);
            pcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_rise) begin
                    state <= ST_RUN;
                    idx   <= '0;
                    nbits <= IW'(res_bits(res_sel, WIDTH));
                end
                ST_RUN: if (step.fire) begin
                    if (step.last) begin
                        state <= ST_HOLD;
                        pcnt  <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (pcnt == POST_LAST) state <= ST_IDLE;
                    else                   pcnt  <= pcnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o    = (state != ST_IDLE);
    assign msb_inv_o = ~data_n_o[WIDTH-1];

    p_launch_from_edge_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_rise));

    p_clk_gated_r3: assert property (@(posedge clk) disable iff (rst)
        bit_clk_o |-> busy_o);

    p_data_on_clk_rise_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_n_o) |-> $rose(bit_clk_o));

    p_stable_at_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $stable(data_n_o));

endmodule

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;
    localparam int W    = 12;
    localparam int HALF = 2;
    localparam int POST = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_in = 1'b0;
    logic [1:0]   res_sel = 2'b00;
    logic         cmp_in;
    logic         busy_o, bit_clk_o, msb_inv_o;
    logic [W-1:0] data_n_o;
    logic [W-1:0] vin = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    // comparator + DAC model: DAC code is the complement of the register
    assign cmp_in = (vin >= ~data_n_o);

    sar_seq_top #(.WIDTH(W), .HALF(HALF), .POST(POST)) u0 (
        .clk(clk), .rst(rst), .start_in(start_in), .res_sel(res_sel),
        .cmp_in(cmp_in), .busy_o(busy_o), .bit_clk_o(bit_clk_o),
        .data_n_o(data_n_o), .msb_inv_o(msb_inv_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
        check(bit_clk_o == 1'b0, "R1", "bit clock in reset", bit_clk_o, 0);
        check(data_n_o == '1, "R1", "register in reset", data_n_o, 12'hFFF);
        rst = 1'b0;
        @(negedge clk);
        check(data_n_o == '1 && !busy_o && !msb_inv_o, "R1", "idle after reset",
              {busy_o, msb_inv_o, data_n_o}, 12'hFFF);
    endtask

    task automatic run_conv(input logic [W-1:0] v, input logic [1:0] sel, input bit poke,
                            input string tag);
        int nb;
        logic [W-1:0] mask, exp_n, first_val, last_val, after_val;
        int n, seen, bcnt, rises, highs;
        bit prev, done;
        nb   = (sel == 2'b01) ? 10 : (sel == 2'b10) ? 8 : 12;
        mask = ~((W'(1) << (W - nb)) - W'(1));
        exp_n = ~(v & mask);
        n = 0; seen = -1; bcnt = 0; rises = 0; highs = 0; prev = 1'b0; done = 1'b0;
        first_val = '0; last_val = '0; after_val = '0;
        @(negedge clk);
        vin = v; res_sel = sel; start_in = 1'b1;
        for (int k = 0; k < 300 && !done; k++) begin
            @(negedge clk);
            n++;
            if (n == 20) start_in = 1'b0;
            if (poke && n == 30) start_in = 1'b1;
            if (poke && n == 36) start_in = 1'b0;
            check(msb_inv_o == ~data_n_o[W-1], "R10", "inverted msb", msb_inv_o, ~data_n_o[W-1]);
            if (busy_o && seen < 0) seen = n;
            if (bit_clk_o && !busy_o) check(0, "R3", "bit clock while idle", 1, 0);
            if (busy_o) begin
                bcnt++;
                last_val = data_n_o;
            end
            if (bit_clk_o && !prev) begin
                rises++;
                if (rises == 1) first_val = data_n_o;
            end
            if (bit_clk_o) highs++;
            prev = bit_clk_o;
            if (seen >= 0 && !busy_o) begin
                done = 1'b1;
                after_val = data_n_o;
            end
        end
        start_in = 1'b0;
        check(done, tag, "conversion finished", done, 1);
        check(seen == 3, "R2", {tag, " launch latency"}, seen, 3);
        check(bcnt == 1 + 2*HALF*nb + POST, "R8", {tag, " busy length"}, bcnt, 1 + 2*HALF*nb + POST);
        check(rises == nb + 1, "R4", {tag, " bit clock edges"}, rises, nb + 1);
        check(highs == HALF*(nb + 1), "R4", {tag, " bit clock high cycles"}, highs, HALF*(nb + 1));
        check(first_val == 12'h7FF, "R5", {tag, " first trial"}, first_val, 12'h7FF);
        check(last_val == exp_n, tag, "result at busy fall", last_val, exp_n);
        check(after_val == last_val, "R8", {tag, " data stable at fall"}, after_val, last_val);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (bit_clk_o || busy_o) check(0, "R3", {tag, " quiet after"}, {busy_o, bit_clk_o}, 0);
        end
        check(data_n_o == exp_n, tag, "result held", data_n_o, exp_n);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        run_conv(12'hA5C, 2'b00, 1'b0, "R6");
        run_conv(12'hFFF, 2'b00, 1'b0, "R6");
        run_conv(12'h000, 2'b00, 1'b0, "R6");
        run_conv(12'h800, 2'b11, 1'b0, "R9");
        run_conv(12'h6E7, 2'b01, 1'b0, "R9");
        run_conv(12'h3C9, 2'b10, 1'b0, "R9");
        run_conv(12'h59A, 2'b00, 1'b1, "R11");
        run_conv(12'h7FF, 2'b01, 1'b1, "R11");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule